// File: doc/BRIEF.md
# Protected Configuration Register Write Gate

This block holds the configuration byte of a serial-memory supervisor and rules on every byte write that a bus slave front end decodes. Each accepted data beat carries a 16-bit address, the data byte and its position within the transaction. The block answers every beat with an acknowledge or ignore decision. Register changes are committed only when the stop event of the transaction arrives.

Writes are guarded at several levels. A volatile write-enable latch must be set before anything is accepted. A second register-enable latch must also be set before the nonvolatile fields may be rewritten. A three-bit block-protect field selects a low address region of the array that refuses writes. A sticky protect-enable bit, combined with the external write-protect pin, freezes both that field and itself.

A combinational query port tells the memory array whether a given address may be written at present. Data beats use a valid/ready handshake. The slave holds `byte_valid` and its fields stable until it sees `byte_ready` high at a clock edge. Ready drops only during the single cycle in which a nonvolatile store is being started.

Top module: `cfg_write_gate`

## Requirements
- R1: The register lives at address FFFFh. A beat to FFFFh whose `byte_cnt` is not 1 is not acknowledged and changes nothing.
- R2: `cfg_reg` bit order, MSB first, is: protect-enable, watchdog[1], watchdog[0], bp[1], bp[0], register-enable latch, write-enable latch, bp[2]. Reset value is 60h.
- R3: The write-enable latch (bit 1) is 0 after reset. While it is 0, the only beat acknowledged is data 02h to FFFFh with count 1. Array beats are not acknowledged, and `arr_wr_ok` is 0.
- R4: An acknowledged 02h sets the write-enable latch at the stop. With the write-enable latch at 1, 00h clears both latches at the stop. Neither raises `nv_store`.
- R5: With the write-enable latch at 1, data 06h sets the register-enable latch (bit 2) at the stop. Any other byte is a full update. It is acknowledged only when the register-enable latch is 1. Otherwise it is not acknowledged and the register is unchanged.
- R6: A full update takes effect only at the stop. In that same cycle `nv_store` is high for exactly one clock, and both enable latches return to 0.
- R7: Protected region by {bp[2],bp[1],bp[0]}: 000, 001 and 010 protect nothing; 011 protects 0000h–1FFFh; 100 protects 0000h–003Fh; 101 protects 0000h–007Fh; 110 protects 0000h–00FFh; 111 protects 0000h–01FFh. `arr_wr_ok` equals the write-enable latch AND NOT (`arr_addr` in the protected region).
- R8: An array beat is acknowledged exactly when the write-enable latch is 1 and the address lies outside the protected region.
- R9: When `wp_pin` and protect-enable are both 1 at the stop, a full update changes only the watchdog field. The bp bits and protect-enable keep their values.
- R10: With `wp_pin` low, a full update rewrites bp and protect-enable, including clearing protect-enable.
- R11: `ack_valid` pulses one cycle after each accepted beat. `byte_ready` is 0 exactly in the cycle where `nv_store` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| byte_valid | input | 1 | Data beat offered |
| byte_ready | output | 1 | Beat can be taken this cycle |
| byte_addr | input | 16 | Target address of the beat |
| byte_data | input | 8 | Data byte |
| byte_cnt | input | 4 | Position of the byte in its transaction, first = 1 |
| stop_valid | input | 1 | One-cycle stop event ending the transaction |
| wp_pin | input | 1 | Write-protect pin level |
| ack_valid | output | 1 | Decision for the previous accepted beat |
| ack_ok | output | 1 | 1 = acknowledge, 0 = ignore |
| nv_store | output | 1 | One-cycle pulse to start a nonvolatile store |
| cfg_reg | output | 8 | Register contents |
| arr_addr | input | 16 | Array address being queried |
| arr_wr_ok | output | 1 | Array address is writable now |

## Verification
The acknowledge decision is due one cycle after the edge that accepts a beat. Register updates and the `nv_store` pulse are due at the edge that samples `stop_valid`. `arr_wr_ok` follows `arr_addr` in the same cycle. The bench drives on falling edges and samples on the next falling edge, so each result is read in the cycle it is due. A scoreboard queue pairs every acknowledge with the beat that produced it.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_WEL_SET, K_CLEAR, K_RWEL_SET, K_FULL, K_ARRAY
  } cmd_kind_t;

  localparam logic [7:0] PAT_WEL_SET  = 8'h02;
  localparam logic [7:0] PAT_RWEL_SET = 8'h06;
  localparam logic [7:0] PAT_CLEAR    = 8'h00;
  localparam logic [7:0] CFG_INIT     = 8'h60;

  // bit positions inside the register byte (decoded by neighbours)
  localparam int P_WPEN = 7;
  localparam int P_WD1  = 6;
  localparam int P_WD0  = 5;
  localparam int P_BP1  = 4;
  localparam int P_BP0  = 3;
  localparam int P_RWEL = 2;
  localparam int P_WEL  = 1;
  localparam int P_BP2  = 0;
endpackage

// File: rtl/cwg_prot_decode.sv
module cwg_prot_decode #(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 8192,
  parameter int PAGE_BYTES  = 64
) (
  input  logic [2:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int LIM_W = ADDR_W + 2;
  logic [LIM_W-1:0] limit;

  always_comb begin
    if (bp[2])
      limit = LIM_W'(PAGE_BYTES) << bp[1:0];
    else if (bp[1:0] == 2'b11)
      limit = LIM_W'(ARRAY_BYTES);
    else
      limit = '0;
    hit = {2'b00, addr} < limit;
  end
endmodule

// File: rtl/cwg_cmd_classify.sv
module cwg_cmd_classify
  import cwg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wel,
  input  logic              rwel,
  input  logic              prot_hit,
  output logic              ack,
  output cmd_kind_t         kind
);
  always_comb begin
    ack  = 1'b0;
    kind = K_NONE;
    if (addr == {ADDR_W{1'b1}}) begin
      if (cnt != CNT_W'(1)) begin
        ack = 1'b0;
      end else if (data == PAT_WEL_SET) begin
        ack = 1'b1; kind = K_WEL_SET;
      end else if (!wel) begin
        ack = 1'b0;
      end else if (data == PAT_CLEAR) begin
        ack = 1'b1; kind = K_CLEAR;
      end else if (data == PAT_RWEL_SET) begin
        ack = 1'b1; kind = K_RWEL_SET;
      end else if (rwel) begin
        ack = 1'b1; kind = K_FULL;
      end
    end else if (wel && !prot_hit) begin
      ack = 1'b1; kind = K_ARRAY;
    end
  end
endmodule

// File: rtl/cwg_reg_core.sv
module cwg_reg_core
  import cwg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       first_beat,
  input  logic       ack_in,
  input  cmd_kind_t  kind_in,
  input  logic [7:0] data_in,
  input  logic       stop,
  input  logic       wp_pin,
  output logic [7:0] cfg_reg,
  output logic [2:0] bp,
  output logic       wel,
  output logic       rwel,
  output logic       ack_valid,
  output logic       ack_ok,
  output logic       nv_store
);
  logic       wpen;
  logic [1:0] wd;
  cmd_kind_t  pend;
  logic [7:0] pend_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpen      <= CFG_INIT[P_WPEN];
      wd        <= {CFG_INIT[P_WD1], CFG_INIT[P_WD0]};
      bp        <= {CFG_INIT[P_BP2], CFG_INIT[P_BP1], CFG_INIT[P_BP0]};
      wel       <= 1'b0;
      rwel      <= 1'b0;
      pend      <= K_NONE;
      pend_data <= '0;
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      nv_store  <= 1'b0;
    end else begin
      ack_valid <= beat;
      nv_store  <= 1'b0;
      if (beat) ack_ok <= ack_in;
      if (beat && first_beat) begin
        pend      <= ack_in ? kind_in : K_NONE;
        pend_data <= data_in;
      end
      if (stop) begin
        pend <= K_NONE;
        case (pend)
          K_WEL_SET:  wel <= 1'b1;
          K_CLEAR:    begin wel <= 1'b0; rwel <= 1'b0; end
          K_RWEL_SET: rwel <= 1'b1;
          K_FULL: begin
            wd <= {pend_data[P_WD1], pend_data[P_WD0]};
            if (!(wp_pin && wpen)) begin
              wpen <= pend_data[P_WPEN];
              bp   <= {pend_data[P_BP2], pend_data[P_BP1], pend_data[P_BP0]};
            end
            wel      <= 1'b0;
            rwel     <= 1'b0;
            nv_store <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_reg         = '0;
    cfg_reg[P_WPEN] = wpen;
    cfg_reg[P_WD1]  = wd[1];
    cfg_reg[P_WD0]  = wd[0];
    cfg_reg[P_BP1]  = bp[1];
    cfg_reg[P_BP0]  = bp[0];
    cfg_reg[P_RWEL] = rwel;
    cfg_reg[P_WEL]  = wel;
    cfg_reg[P_BP2]  = bp[2];
  end
endmodule

// File: rtl/cfg_write_gate.sv
module cfg_write_gate
  import cwg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 4,
  parameter int ARRAY_BYTES = 8192,
  parameter int PAGE_BYTES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [7:0]        byte_data,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              stop_valid,
  input  logic              wp_pin,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              nv_store,
  output logic [7:0]        cfg_reg,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic              arr_wr_ok
);
  localparam int N_PORTS = 2;

  logic [2:0]        bp;
  logic              wel, rwel, beat, cls_ack;
  cmd_kind_t         cls_kind;
  logic [ADDR_W-1:0] q_addr [N_PORTS];
  logic              q_hit  [N_PORTS];

  assign q_addr[0] = byte_addr;
  assign q_addr[1] = arr_addr;

  generate
    for (genvar g = 0; g < N_PORTS; g++) begin : g_dec
      cwg_prot_decode #(
        .ADDR_W(ADDR_W), .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES)
      ) i_dec (.bp(bp), .addr(q_addr[g]), .hit(q_hit[g]));
    end
  endgenerate

  assign byte_ready = !nv_store;
  assign beat       = byte_valid && byte_ready;
  assign arr_wr_ok  = wel && !q_hit[1];

  cwg_cmd_classify #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_cls (
    .addr(byte_addr), .data(byte_data), .cnt(byte_cnt),
    .wel(wel), .rwel(rwel), .prot_hit(q_hit[0]),
    .ack(cls_ack), .kind(cls_kind)
  );

  cwg_reg_core i_core (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .first_beat(byte_cnt == CNT_W'(1)),
    .ack_in(cls_ack), .kind_in(cls_kind), .data_in(byte_data),
    .stop(stop_valid), .wp_pin(wp_pin),
    .cfg_reg(cfg_reg), .bp(bp), .wel(wel), .rwel(rwel),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .nv_store(nv_store)
  );
endmodule

// File: rtl/cfg_write_gate_chk.sv
module cfg_write_gate_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic              byte_ready,
  input logic [ADDR_W-1:0] byte_addr,
  input logic [7:0]        byte_data,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic              wp_pin,
  input logic              ack_valid,
  input logic              ack_ok,
  input logic              nv_store,
  input logic [7:0]        cfg_reg
);
  logic beat;
  assign beat = byte_valid && byte_ready;

  AST_EXTRA_BYTE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && byte_addr == {ADDR_W{1'b1}} && byte_cnt != CNT_W'(1)) |=> !ack_ok); // R1
  AST_LOCKED_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !cfg_reg[1] && byte_data != 8'h02) |=> (ack_valid && !ack_ok)); // R3
  AST_STORE_CLEARS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    nv_store |-> (!cfg_reg[1] && !cfg_reg[2])); // R6
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nv_store |=> !nv_store); // R6
  AST_HW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pin && cfg_reg[7]) |=> $stable({cfg_reg[7], cfg_reg[4:3], cfg_reg[0]})); // R9
  AST_ACK_PER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> ack_valid); // R11
  AST_READY_LOW_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    nv_store |-> !byte_ready); // R11
endmodule

bind cfg_write_gate cfg_write_gate_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
  .byte_addr(byte_addr), .byte_data(byte_data), .byte_cnt(byte_cnt),
  .wp_pin(wp_pin), .ack_valid(ack_valid), .ack_ok(ack_ok),
  .nv_store(nv_store), .cfg_reg(cfg_reg)
);

// File: tb/test_cfg_write_gate.sv
`timescale 1ns/1ps
module test_cfg_write_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic        byte_ready;
  logic [15:0] byte_addr = '0;
  logic [7:0]  byte_data = '0;
  logic [3:0]  byte_cnt = 4'd1;
  logic        stop_valid = 1'b0;
  logic        wp_pin = 1'b0;
  logic        ack_valid, ack_ok, nv_store, arr_wr_ok;
  logic [7:0]  cfg_reg;
  logic [15:0] arr_addr = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  cfg_write_gate i_cfg_write_gate (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_addr(byte_addr), .byte_data(byte_data), .byte_cnt(byte_cnt),
    .stop_valid(stop_valid), .wp_pin(wp_pin), .ack_valid(ack_valid),
    .ack_ok(ack_ok), .nv_store(nv_store), .cfg_reg(cfg_reg),
    .arr_addr(arr_addr), .arr_wr_ok(arr_wr_ok)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare each decision with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected ack", 1, 0);
      else check(tag_q.pop_front(), ack_ok, exp_q.pop_front());
    end
  end

  task automatic send_byte(input logic [15:0] a, input logic [7:0] d,
                           input logic [3:0] c, input bit exp, input string tag);
    @(negedge clk);
    while (!byte_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    byte_addr = a; byte_data = d; byte_cnt = c; byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic do_stop(input bit exp_store, input string tag);
    @(negedge clk);
    stop_valid = 1'b1;
    @(negedge clk);
    stop_valid = 1'b0;
    check({tag, " store"}, nv_store, exp_store);
    if (exp_store) check("R11 ready low on store", byte_ready, 0);
    @(negedge clk);
    check("R6 store single", nv_store, 0);
  endtask

  task automatic reg_cmd(input logic [7:0] d, input bit exp_ack, input bit exp_store,
                         input string tag);
    send_byte(16'hFFFF, d, 4'd1, exp_ack, tag);
    do_stop(exp_store, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset value", cfg_reg, 8'h60);
    arr_addr = 16'h0100;
    #1 check("R3 arr locked", arr_wr_ok, 0);
    check("R11 ready idle", byte_ready, 1);

    send_byte(16'h0100, 8'hAA, 4'd1, 0, "R3 array nack");
    send_byte(16'hFFFF, 8'h06, 4'd1, 0, "R3 rwel nack when locked");
    do_stop(0, "R3");
    check("R3 unchanged", cfg_reg, 8'h60);

    send_byte(16'hFFFF, 8'h02, 4'd1, 1, "R4 wel set ack");
    send_byte(16'hFFFF, 8'h55, 4'd2, 0, "R1 extra byte nack");
    do_stop(0, "R4");
    check("R4 wel set", cfg_reg, 8'h62);

    reg_cmd(8'h98, 0, 0, "R5 full without rwel");
    check("R5 unchanged", cfg_reg, 8'h62);
    reg_cmd(8'h06, 1, 0, "R5 rwel set");
    check("R5 rwel set", cfg_reg, 8'h66);

    send_byte(16'hFFFF, 8'h29, 4'd1, 1, "R6 full ack");
    check("R6 not before stop", cfg_reg, 8'h66);
    do_stop(1, "R6");
    check("R2 R6 full value", cfg_reg, 8'h29);

    reg_cmd(8'h02, 1, 0, "R4 wel again");
    check("R4 wel again value", cfg_reg, 8'h2B);
    arr_addr = 16'h007F;
    #1 check("R7 bp101 edge in", arr_wr_ok, 0);
    arr_addr = 16'h0080;
    #1 check("R7 bp101 edge out", arr_wr_ok, 1);
    send_byte(16'h0040, 8'h11, 4'd1, 0, "R8 protected nack");
    send_byte(16'h0200, 8'h11, 4'd1, 1, "R8 open ack");
    send_byte(16'h0201, 8'h12, 4'd2, 1, "R8 second byte ack");
    do_stop(0, "R8");

    reg_cmd(8'h06, 1, 0, "R5 rwel");
    reg_cmd(8'hF8, 1, 1, "R10 soft write");
    check("R10 value", cfg_reg, 8'hF8);
    reg_cmd(8'h02, 1, 0, "R4 wel");
    arr_addr = 16'h1FFF;
    #1 check("R7 bp011 top", arr_wr_ok, 0);
    arr_addr = 16'h0000;
    #1 check("R7 bp011 bottom", arr_wr_ok, 0);

    wp_pin = 1'b1;
    reg_cmd(8'h06, 1, 0, "R5 rwel hw");
    check("R9 latches", cfg_reg, 8'hFE);
    reg_cmd(8'h00 | 8'h01, 1, 1, "R9 hw write");
    check("R9 frozen bp wpen", cfg_reg, 8'h98);

    wp_pin = 1'b0;
    reg_cmd(8'h02, 1, 0, "R4 wel");
    reg_cmd(8'h06, 1, 0, "R5 rwel");
    check("R5 latches", cfg_reg, 8'h9E);
    reg_cmd(8'h01, 1, 1, "R10 clear wpen");
    check("R10 wpen cleared", cfg_reg, 8'h01);
    reg_cmd(8'h02, 1, 0, "R4 wel");
    check("R4 wel value", cfg_reg, 8'h03);
    reg_cmd(8'h00, 1, 0, "R4 clear");
    check("R4 cleared", cfg_reg, 8'h01);

    repeat (2) @(negedge clk);
    check("R11 scoreboard empty", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule